// File: doc/BRIEF.md
# Out-of-Order Load Issue Queue

This block holds loads waiting to go to the data memory port. Each entry stores a physical address, a load tag and the tags of its source operands. The operand-wakeup port broadcasts physical-register tags as producers complete. An entry whose sources have all been seen ready latches a sticky ready bit, and from then on it does not look at its operands again.

Every cycle the queue considers all held entries from oldest to youngest. An entry is eligible when it is ready and the memory bank its address maps to is not busy. Blocked entries are passed over, so the scan does not stop at them. Up to a per-cycle budget of eligible entries issue together. They leave the queue, and each appears on an issue slot with its address, its tag and the current cycle number.

Age is tracked with a relative-age matrix over a fixed array of slots. A slot freed in the middle of the array is reused by the next allocation. Allocation takes one load per cycle and is refused while every slot is occupied.

Top module: `lq_issuer`

## Requirements
- R1: After reset no issue slot is valid, `alloc_stall` is low and `iss_cycle` reads 0.
- R2: Issue slot k carries the k-th oldest eligible entry, counted in allocation order. Slot k uses bits [k*ADDR_W +: ADDR_W] of `iss_addr` and [k*TAG_W +: TAG_W] of `iss_tag`.
- R3: An entry whose operands are not all ready does not issue, and younger ready entries still issue past it. Source s of an allocation is given by bits [s*PREG_W +: PREG_W] of `alloc_src_tag` and by bit s of `alloc_src_rdy`.
- R4: A wakeup whose tag matches a pending source of a held entry makes that source ready from the next cycle. The entry cannot issue in the cycle of the wakeup itself.
- R5: Once an entry is ready it stays eligible in every later cycle whose bank is free, until it issues, with no further wakeup needed.
- R6: An entry whose bank is busy does not issue, and other eligible entries still do. The bank is the low log2(NBANK) address bits, and `mem_busy` bit b marks bank b as busy.
- R7: The number of loads issued in a cycle equals the smallest of three values: `issue_budget`, ISSUE_W and the count of eligible entries. A budget of 0 issues nothing, and a budget above ISSUE_W is clipped to ISSUE_W.
- R8: An issued entry leaves the queue and never issues again. Its slot becomes free for a later allocation.
- R9: `iss_cycle` equals the number of clock edges since reset was released, modulo 2^CYC_W.
- R10: `alloc_stall` is high exactly when all DEPTH slots are held. An allocation made during stall is dropped, and that load never issues.
- R11: An allocation whose source tag matches a wakeup in the same cycle records that source as ready.
- R12: Valid issue slots are packed from slot 0 upward, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate a load this cycle |
| alloc_addr | input | ADDR_W | Physical address of the new load |
| alloc_tag | input | TAG_W | Tag of the new load |
| alloc_src_tag | input | NSRC*PREG_W | Source register tags, source s at [s*PREG_W +: PREG_W] |
| alloc_src_rdy | input | NSRC | Source s already ready at allocation |
| alloc_stall | output | 1 | Queue full; allocation refused |
| wake_valid | input | 1 | A register-ready broadcast is present |
| wake_preg | input | PREG_W | Register tag being broadcast |
| mem_busy | input | NBANK | Bank b cannot accept a request this cycle |
| issue_budget | input | clog2(ISSUE_W+1) | Maximum loads to issue this cycle |
| iss_valid | output | ISSUE_W | Issue slot k holds a load |
| iss_addr | output | ISSUE_W*ADDR_W | Addresses of issued loads |
| iss_tag | output | ISSUE_W*TAG_W | Tags of issued loads |
| iss_cycle | output | CYC_W | Cycle stamp for the loads issued this cycle |

## Verification
The assertions take for granted that `mem_busy` and `issue_budget` are stable from just after a clock edge until the next one, because they feed the issue slots combinationally. The bank check further assumes that a load's address does not change while it sits in the queue. The stimulus changes every input only just after a rising edge and holds it for the whole cycle. It draws source and wakeup tags from a small pool, so that pending operands are released often and the queue both fills to stall and drains.

// File: rtl/lq_pkg.sv
// Package: default sizes shared by the load issue queue and its checker.
// Assumes: nothing; only constants live here.
package lq_pkg;
    localparam int LQ_DEPTH   = 8;
    localparam int LQ_ADDR_W  = 16;
    localparam int LQ_TAG_W   = 6;
    localparam int LQ_PREG_W  = 6;
    localparam int LQ_NSRC    = 2;
    localparam int LQ_ISSUE_W = 2;
    localparam int LQ_NBANK   = 4;
    localparam int LQ_CYC_W   = 16;
endpackage

// File: rtl/lq_src_slot.sv
// Module: operand tracker for one queue slot.
// It captures the source tags on allocation and watches the wakeup broadcast.
// It latches a sticky ready bit once every source is ready, and from then on
// it no longer evaluates the sources.
// Assumes: load_i only pulses for a slot that is free.
module lq_src_slot #(
    parameter int NSRC   = 2,
    parameter int PREG_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic [NSRC*PREG_W-1:0] src_tag_i,
    input  logic [NSRC-1:0]        src_rdy_i,
    input  logic                   wake_valid_i,
    input  logic [PREG_W-1:0]      wake_preg_i,
    output logic                   ready_o
);
    logic [PREG_W-1:0] tag_q [NSRC];
    logic [NSRC-1:0]   src_q;
    logic [NSRC-1:0]   src_nxt;

    // Next source readiness: new allocation or held tags, merged with wakeup.
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            if (load_i)
                src_nxt[s] = src_rdy_i[s] |
                             (wake_valid_i && src_tag_i[s*PREG_W +: PREG_W] == wake_preg_i);
            else
                src_nxt[s] = src_q[s] | (wake_valid_i && tag_q[s] == wake_preg_i);
        end
    end

    // State update: capture on allocate, otherwise evaluate only until ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= '0;
            ready_o <= 1'b0;
            for (int s = 0; s < NSRC; s++) tag_q[s] <= '0;
        end else if (load_i) begin
            for (int s = 0; s < NSRC; s++) tag_q[s] <= src_tag_i[s*PREG_W +: PREG_W];
            src_q   <= src_nxt;
            ready_o <= &src_nxt;
        end else if (!ready_o) begin
            src_q   <= src_nxt;
            ready_o <= &src_nxt;
        end
    end
endmodule

// File: rtl/lq_age_matrix.sv
// Module: relative-age matrix. Bit [i][j] set means slot j is older than slot i.
// A new entry becomes younger than every held entry, and its column is
// cleared so that no existing entry sees it as older.
// Assumes: at most one alloc bit is set, and only for a slot not in valid_i.
module lq_age_matrix #(
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DEPTH-1:0]            alloc_oh_i,
    input  logic [DEPTH-1:0]            valid_i,
    output logic [DEPTH-1:0][DEPTH-1:0] older_o
);
    // Row write on allocation, column clear for the slot being reused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older_o <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (alloc_oh_i[i])
                        older_o[i][j] <= valid_i[j] && (i != j);
                    else if (alloc_oh_i[j])
                        older_o[i][j] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/lq_pick.sv
// Module: oldest-first multi-grant picker. Grant k takes the oldest entry
// still eligible after grants 0..k-1, and only while k is below the limit.
// Assumes: older_i is a strict order over the eligible entries.
module lq_pick #(
    parameter int DEPTH   = 8,
    parameter int ISSUE_W = 2,
    parameter int BUD_W   = 2
) (
    input  logic [DEPTH-1:0]              elig_i,
    input  logic [DEPTH-1:0][DEPTH-1:0]   older_i,
    input  logic [BUD_W-1:0]              limit_i,
    output logic [ISSUE_W-1:0][DEPTH-1:0] grant_o
);
    logic [ISSUE_W:0][DEPTH-1:0] rem;

    assign rem[0] = elig_i;

    for (genvar k = 0; k < ISSUE_W; k++) begin : g_round
        for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            // Entry i wins round k when no remaining entry is older than it.
            assign grant_o[k][i] = (limit_i > BUD_W'(k)) && rem[k][i] &&
                                   !(|(rem[k] & older_i[i]));
        end
        assign rem[k+1] = rem[k] & ~grant_o[k];
    end
endmodule

// File: rtl/lq_issuer.sv
// Module: load issue queue top. It holds loads in a slot array and
// allocates one per cycle into the lowest free slot. It issues up to
// min(budget, ISSUE_W) of the oldest eligible loads each cycle on
// combinational issue slots, and removes them at the clock edge.
// Assumes: inputs stable from just after an edge until the next; NBANK >= 2.
module lq_issuer import lq_pkg::*; #(
    parameter int DEPTH   = LQ_DEPTH,
    parameter int ADDR_W  = LQ_ADDR_W,
    parameter int TAG_W   = LQ_TAG_W,
    parameter int PREG_W  = LQ_PREG_W,
    parameter int NSRC    = LQ_NSRC,
    parameter int ISSUE_W = LQ_ISSUE_W,
    parameter int NBANK   = LQ_NBANK,
    parameter int CYC_W   = LQ_CYC_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_valid,
    input  logic [ADDR_W-1:0]            alloc_addr,
    input  logic [TAG_W-1:0]             alloc_tag,
    input  logic [NSRC*PREG_W-1:0]       alloc_src_tag,
    input  logic [NSRC-1:0]              alloc_src_rdy,
    output logic                         alloc_stall,
    input  logic                         wake_valid,
    input  logic [PREG_W-1:0]            wake_preg,
    input  logic [NBANK-1:0]             mem_busy,
    input  logic [$clog2(ISSUE_W+1)-1:0] issue_budget,
    output logic [ISSUE_W-1:0]           iss_valid,
    output logic [ISSUE_W*ADDR_W-1:0]    iss_addr,
    output logic [ISSUE_W*TAG_W-1:0]     iss_tag,
    output logic [CYC_W-1:0]             iss_cycle
);
    localparam int BUD_W  = $clog2(ISSUE_W + 1);
    localparam int BANK_W = $clog2(NBANK);

    logic [DEPTH-1:0]              valid_q;
    logic [DEPTH-1:0]              rdy;
    logic [DEPTH-1:0]              alloc_oh;
    logic [DEPTH-1:0]              bank_blk;
    logic [DEPTH-1:0]              elig;
    logic [DEPTH-1:0]              issue_mask;
    logic [ADDR_W-1:0]             addr_q [DEPTH];
    logic [TAG_W-1:0]              tag_q  [DEPTH];
    logic [DEPTH-1:0][DEPTH-1:0]   older;
    logic [ISSUE_W-1:0][DEPTH-1:0] grant;
    logic [BUD_W-1:0]              limit;
    logic [CYC_W-1:0]              cyc_q;

    assign alloc_stall = &valid_q;
    assign iss_cycle   = cyc_q;
    assign elig        = valid_q & rdy & ~bank_blk;
    assign limit       = (issue_budget > BUD_W'(ISSUE_W)) ? BUD_W'(ISSUE_W) : issue_budget;

    // Lowest free slot receives an accepted allocation.
    always_comb begin
        logic found;
        found    = 1'b0;
        alloc_oh = '0;
        for (int e = 0; e < DEPTH; e++) begin
            if (!valid_q[e] && !found && alloc_valid) begin
                alloc_oh[e] = 1'b1;
                found       = 1'b1;
            end
        end
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        lq_src_slot #(.NSRC(NSRC), .PREG_W(PREG_W)) u_src (
            .clk          (clk),
            .rst_n        (rst_n),
            .load_i       (alloc_oh[e]),
            .src_tag_i    (alloc_src_tag),
            .src_rdy_i    (alloc_src_rdy),
            .wake_valid_i (wake_valid),
            .wake_preg_i  (wake_preg),
            .ready_o      (rdy[e])
        );
        assign bank_blk[e] = mem_busy[addr_q[e][BANK_W-1:0]];
    end

    lq_age_matrix #(.DEPTH(DEPTH)) u_age (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_oh_i (alloc_oh),
        .valid_i    (valid_q),
        .older_o    (older)
    );

    lq_pick #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .BUD_W(BUD_W)) u_pick (
        .elig_i  (elig),
        .older_i (older),
        .limit_i (limit),
        .grant_o (grant)
    );

    // Issue slot outputs: one-hot grants select address and tag.
    always_comb begin
        issue_mask = '0;
        iss_addr   = '0;
        iss_tag    = '0;
        for (int k = 0; k < ISSUE_W; k++) begin
            iss_valid[k] = |grant[k];
            issue_mask   = issue_mask | grant[k];
            for (int e = 0; e < DEPTH; e++) begin
                if (grant[k][e]) begin
                    iss_addr[k*ADDR_W +: ADDR_W] = addr_q[e];
                    iss_tag[k*TAG_W +: TAG_W]    = tag_q[e];
                end
            end
        end
    end

    // Slot occupancy, payload capture and the free-running cycle stamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            cyc_q   <= '0;
            for (int e = 0; e < DEPTH; e++) begin
                addr_q[e] <= '0;
                tag_q[e]  <= '0;
            end
        end else begin
            valid_q <= (valid_q & ~issue_mask) | alloc_oh;
            cyc_q   <= cyc_q + 1'b1;
            for (int e = 0; e < DEPTH; e++) begin
                if (alloc_oh[e]) begin
                    addr_q[e] <= alloc_addr;
                    tag_q[e]  <= alloc_tag;
                end
            end
        end
    end
endmodule

// File: rtl/lq_issuer_chk.sv
// Module: property checker for the load issue queue, bound to every instance.
// Assumes: inputs are held stable across each clock period.
module lq_issuer_chk #(
    parameter int DEPTH   = 8,
    parameter int ADDR_W  = 16,
    parameter int TAG_W   = 6,
    parameter int PREG_W  = 6,
    parameter int NSRC    = 2,
    parameter int ISSUE_W = 2,
    parameter int NBANK   = 4,
    parameter int CYC_W   = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         alloc_valid,
    input logic [ADDR_W-1:0]            alloc_addr,
    input logic [TAG_W-1:0]             alloc_tag,
    input logic [NSRC*PREG_W-1:0]       alloc_src_tag,
    input logic [NSRC-1:0]              alloc_src_rdy,
    input logic                         alloc_stall,
    input logic                         wake_valid,
    input logic [PREG_W-1:0]            wake_preg,
    input logic [NBANK-1:0]             mem_busy,
    input logic [$clog2(ISSUE_W+1)-1:0] issue_budget,
    input logic [ISSUE_W-1:0]           iss_valid,
    input logic [ISSUE_W*ADDR_W-1:0]    iss_addr,
    input logic [ISSUE_W*TAG_W-1:0]     iss_tag,
    input logic [CYC_W-1:0]             iss_cycle
);
    localparam int BANK_W = $clog2(NBANK);
    logic started;

    // Marks the cycles after the first edge out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> iss_cycle == CYC_W'($past(iss_cycle) + 1'b1)); // R9
    AST_SLOT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid & (iss_valid + 1'b1)) == '0); // R12
    AST_BUDGET_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(iss_valid) <= int'(issue_budget)); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_stall && iss_valid == '0) |=> alloc_stall); // R10

    for (genvar k = 0; k < ISSUE_W; k++) begin : g_bank
        AST_BANK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[k] |-> !mem_busy[iss_addr[k*ADDR_W +: BANK_W]]); // R6
    end
endmodule

bind lq_issuer lq_issuer_chk #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .PREG_W(PREG_W),
    .NSRC(NSRC), .ISSUE_W(ISSUE_W), .NBANK(NBANK), .CYC_W(CYC_W)
) u_chk (.*);

// File: tb/lq_issuer_tb.sv
// Bench: a reference queue model ordered by allocation count, driven by
// directed corner cases followed by seeded random traffic.
module lq_issuer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8, ADDR_W = 16, TAG_W = 6, PREG_W = 6;
    localparam int NSRC = 2, ISSUE_W = 2, NBANK = 4, CYC_W = 16;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      alloc_valid = 1'b0;
    logic [ADDR_W-1:0]         alloc_addr = '0;
    logic [TAG_W-1:0]          alloc_tag = '0;
    logic [NSRC*PREG_W-1:0]    alloc_src_tag = '0;
    logic [NSRC-1:0]           alloc_src_rdy = '0;
    logic                      alloc_stall;
    logic                      wake_valid = 1'b0;
    logic [PREG_W-1:0]         wake_preg = '0;
    logic [NBANK-1:0]          mem_busy = '0;
    logic [1:0]                issue_budget = 2'd2;
    logic [ISSUE_W-1:0]        iss_valid;
    logic [ISSUE_W*ADDR_W-1:0] iss_addr;
    logic [ISSUE_W*TAG_W-1:0]  iss_tag;
    logic [CYC_W-1:0]          iss_cycle;

    lq_issuer u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0, age_ctr = 0;
    bit done = 1'b0;
    bit m_v [DEPTH];
    int m_age [DEPTH], m_addr [DEPTH], m_tag [DEPTH];
    int m_st [DEPTH][NSRC];
    bit m_sr [DEPTH][NSRC];

    function automatic bit m_ready(int i);
        return m_sr[i][0] && m_sr[i][1];
    endfunction

    function automatic int m_count();
        int c = 0;
        for (int i = 0; i < DEPTH; i++) c += m_v[i];
        return c;
    endfunction

    task automatic check(string req, bit ok, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock: compare outputs against the model, then advance the model.
    task automatic step(string req);
        bit taken [DEPTH];
        int pick [ISSUE_W];
        int lim, cnt;
        @(negedge clk);
        #1;
        for (int i = 0; i < DEPTH; i++) taken[i] = 1'b0;
        lim = (issue_budget > ISSUE_W) ? ISSUE_W : int'(issue_budget);
        for (int k = 0; k < ISSUE_W; k++) begin
            int best = -1;
            if (k < lim)
                for (int i = 0; i < DEPTH; i++)
                    if (m_v[i] && m_ready(i) && !mem_busy[m_addr[i] % NBANK] && !taken[i] &&
                        (best < 0 || m_age[i] < m_age[best])) best = i;
            pick[k] = best;
            if (best >= 0) taken[best] = 1'b1;
        end
        for (int k = 0; k < ISSUE_W; k++) begin
            check(req, iss_valid[k] == (pick[k] >= 0), $sformatf("slot%0d valid", k),
                  int'(iss_valid[k]), int'(pick[k] >= 0));
            if (pick[k] >= 0 && iss_valid[k]) begin
                check(req, int'(iss_addr[k*ADDR_W +: ADDR_W]) == m_addr[pick[k]],
                      $sformatf("slot%0d addr", k), int'(iss_addr[k*ADDR_W +: ADDR_W]), m_addr[pick[k]]);
                check(req, int'(iss_tag[k*TAG_W +: TAG_W]) == m_tag[pick[k]],
                      $sformatf("slot%0d tag", k), int'(iss_tag[k*TAG_W +: TAG_W]), m_tag[pick[k]]);
            end
        end
        if (iss_valid != '0)
            check("R9", int'(iss_cycle) == (cyc % (1 << CYC_W)), "cycle stamp", int'(iss_cycle), cyc % (1 << CYC_W));
        check("R12", (iss_valid & (iss_valid + 1'b1)) == '0, "slot packing", int'(iss_valid), 0);
        cnt = m_count();
        check("R10", alloc_stall == (cnt == DEPTH), "stall", int'(alloc_stall), int'(cnt == DEPTH));
        for (int i = 0; i < DEPTH; i++) if (taken[i]) m_v[i] = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (m_v[i])
                for (int s = 0; s < NSRC; s++)
                    if (wake_valid && m_st[i][s] == int'(wake_preg)) m_sr[i][s] = 1'b1;
        if (alloc_valid && cnt < DEPTH) begin
            int f = -1;
            for (int i = 0; i < DEPTH; i++) if (!m_v[i] && f < 0) f = i;
            m_v[f] = 1'b1; m_addr[f] = int'(alloc_addr); m_tag[f] = int'(alloc_tag);
            m_age[f] = age_ctr++;
            for (int s = 0; s < NSRC; s++) begin
                m_st[f][s] = int'(alloc_src_tag[s*PREG_W +: PREG_W]);
                m_sr[f][s] = alloc_src_rdy[s] ||
                             (wake_valid && m_st[f][s] == int'(wake_preg));
            end
        end
        @(posedge clk);
        cyc++;
        #1;
    endtask

    task automatic quiet(int budget);
        alloc_valid = 1'b0; wake_valid = 1'b0; mem_busy = '0; issue_budget = 2'(budget);
    endtask

    task automatic put(int addr, int tag, int t0, bit r0, int t1, bit r1);
        alloc_valid   = 1'b1;
        alloc_addr    = ADDR_W'(addr);
        alloc_tag     = TAG_W'(tag);
        alloc_src_tag = {PREG_W'(t1), PREG_W'(t0)};
        alloc_src_rdy = {r1, r0};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5a));
        for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", iss_valid == '0, "valid in reset", int'(iss_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        cyc = 1;
        check("R1", iss_valid == '0 && !alloc_stall, "idle after reset", int'(iss_valid), 0);
        check("R1", iss_cycle == 16'd1, "stamp after first edge", int'(iss_cycle), 1);

        // R3: an unready older load is passed over by a ready younger one.
        quiet(0); put('h100, 1, 5, 0, 1, 1); step("R3");
        put('h104, 2, 3, 1, 4, 1); step("R3");
        quiet(2); step("R3");
        // R4: a wakeup releases tag 5 only from the following cycle.
        wake_valid = 1'b1; wake_preg = 6'd5; step("R4");
        quiet(2); step("R4");
        // R5: after the wakeup the entry waits out busy banks and then issues.
        quiet(2); put('h208, 3, 6, 0, 1, 1); step("R5");
        quiet(2); mem_busy = '1; wake_valid = 1'b1; wake_preg = 6'd6; step("R5");
        quiet(2); mem_busy = '1; repeat (3) step("R5");
        quiet(2); step("R5");
        // R6: the older load on a busy bank yields to a younger one.
        quiet(0); put('h301, 4, 1, 1, 1, 1); step("R6");
        put('h302, 5, 1, 1, 1, 1); step("R6");
        quiet(2); mem_busy = 4'b0010; step("R6");
        quiet(2); step("R6");
        // R7: budget 0, then 3 clipped to two, then 1.
        quiet(0);
        for (int i = 0; i < 4; i++) begin
            put('h400 + i, 8 + i, 1, 1, 1, 1); step("R7");
        end
        quiet(0); step("R7");
        quiet(3); step("R7");
        quiet(1); step("R7");
        quiet(2); step("R7");
        // R10: fill every slot, then offer a ninth load that must be dropped.
        quiet(0);
        for (int i = 0; i < DEPTH; i++) begin
            put('h500 + i, 16 + i, 7, 0, 1, 1); step("R10");
        end
        put('h5ff, 63, 1, 1, 1, 1); step("R10");
        // R8: drain; each load issues once and the dropped one never does.
        quiet(2); wake_valid = 1'b1; wake_preg = 6'd7; step("R8");
        quiet(2); repeat (6) step("R8");
        // R11: allocation catches a wakeup for its source in the same cycle.
        quiet(2); put('h600, 30, 9, 0, 1, 1); wake_valid = 1'b1; wake_preg = 6'd9; step("R11");
        quiet(2); step("R11");

        // R2: seeded random traffic against the model.
        for (int n = 0; n < 4000; n++) begin
            alloc_valid  = ($urandom % 10) < 6;
            put($urandom % 65536, $urandom % 64, $urandom % 12, ($urandom % 3) == 0,
                $urandom % 12, ($urandom % 3) == 0);
            alloc_valid  = ($urandom % 10) < 6;
            wake_valid   = ($urandom % 2) == 0;
            wake_preg    = PREG_W'($urandom % 12);
            mem_busy     = NBANK'($urandom);
            issue_budget = 2'($urandom);
            step("R2");
        end
        quiet(2); wake_valid = 1'b0; repeat (4) step("R2");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule